// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command bus of a single-rank SDR SDRAM from reset onward. It first holds the bus idle for the power-up settling time. It then runs the fixed startup order: one precharge of all banks, eight auto-refresh commands and a mode register load. After that it raises a ready flag.

From then on it schedules refresh. An interval counter accrues one owed refresh per average refresh period. The block asks the access arbiter for a slot and waits until it gets a grant. If eight refreshes pile up without a grant, the deadline counts as missed. The block then takes the bus without a grant and issues a back-to-back pair of refreshes. A self-refresh request drives the device into self-refresh by issuing a refresh with the clock enable low. On exit the block holds the bus quiet for two clocks plus a full row cycle.

All waits are given in nanoseconds and turned into whole clock cycles, rounded up, from a clock-period parameter. The mode word is built from the CAS latency, burst length and wrap-order parameters.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: After reset release the block drives only NOP for ceil(T_INIT_NS·1000/CLK_PERIOD_PS) clock edges (10000 at the defaults). The first command is then Precharge All, with address bit 10 high.
- R2: The first Auto Refresh follows Precharge All by ceil(T_RP/tCK) cycles (2). Exactly 8 Auto Refresh commands follow, spaced ceil(T_RC/tCK) cycles apart (7). The Mode Register Set comes 7 cycles after the eighth refresh.
- R3: The Mode Register Set carries the mode word on the address bus, with bank lines at 0. The fields are: burst code in bits 2:0 (1→0, 2→1, 4→2, 8→3, full page→7), wrap order in bit 3 (1 = interleaved), CAS latency in bits 6:4, and all other bits 0. At the defaults (CL 3, burst 8, sequential) the word is 0x033.
- R4: init_done_o goes high MRD_CYC cycles (2) after the Mode Register Set and stays high.
- R5: One refresh is owed every ceil(T_REFI/tCK) cycles (1560), counted from the first cycle with init_done_o high. refresh_req_o is high while the block is idle and a refresh is owed, and stays high until a grant. The cycle after a sampled grant carries an Auto Refresh, and refresh_req_o is low in that cycle.
- R6: When 8 refreshes are owed, the block issues two Auto Refresh commands 7 cycles apart without a grant. The first comes one cycle after the eighth one became owed. refresh_req_o is low until the second has finished its row cycle.
- R7: A self-refresh request seen while idle gives an Auto Refresh with cke_o low in the next cycle. cke_o then stays low and the bus stays NOP while the request is held.
- R8: When the request drops, cke_o returns high, and no command is issued until ceil(T_RC/tCK)+2 cycles (9) after the first cycle with cke_o high.
- R9: Command encoding as {cs_no, ras_no, cas_no, we_no} is: NOP 0111, Precharge 0010, Auto Refresh 0001, Mode Register Set 0000. Every cycle without a command carries NOP.
- R10: Every wait is rounded up to whole cycles. At a 15 ns clock the power-up wait is 6667 edges, the precharge wait 2 cycles and the row cycle 5 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sr_req_i | input | 1 | Self-refresh request, held high for the whole self-refresh |
| refresh_grant_i | input | 1 | Arbiter grant for an owed refresh |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |
| addr_o | output | ADDR_W | Address lines |
| ba_o | output | BANK_W | Bank select lines |
| init_done_o | output | 1 | Startup sequence complete |
| refresh_req_o | output | 1 | Refresh slot request to the arbiter |

## Verification
Commands are combinational from the state register. A grant or self-request driven in one cycle therefore shows its command in the next sampled cycle. A command issued in cycle k allows the next command no earlier than cycle k plus the rounded wait. The bench counts clock samples from one observed command to the next and compares each gap with the exact figure from R1, R2, R5, R6 and R8. It samples and drives on the falling edge and reads each expected cycle exactly, not within a tolerance.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  typedef enum logic [4:0] {
    ST_PWRUP, ST_PRE, ST_WAIT_RP, ST_IREF, ST_WAIT_IREF, ST_MRS, ST_WAIT_MRD,
    ST_IDLE, ST_AREF, ST_WAIT_AREF, ST_FREF1, ST_WAIT_F1, ST_FREF2, ST_WAIT_F2,
    ST_SR_ENTER, ST_SR_HOLD, ST_SR_EXIT
  } seq_state_e;

  function automatic int ceil_cyc(int t_ns, int per_ps);
    return (t_ns * 1000 + per_ps - 1) / per_ps;
  endfunction

  function automatic int bl_code(int bl);
    case (bl)
      1: return 0;
      2: return 1;
      4: return 2;
      8: return 3;
      default: return 7;  // full page
    endcase
  endfunction

  function automatic int mode_word(int cl, int bl, int interleave);
    return (cl << 4) | ((interleave != 0 ? 1 : 0) << 3) | bl_code(bl);
  endfunction
endpackage

// File: rtl/seq_delay.sv
module seq_delay #(
  parameter int W       = 16,
  parameter int RST_VAL = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= W'(RST_VAL);
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q <= W'(1));
endmodule

// File: rtl/refresh_ticker.sv
module refresh_ticker #(
  parameter int N_REFI   = 1560,
  parameter int PEND_MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic dec_i,
  output logic owed_o,
  output logic full_o
);
  localparam int CNT_W  = $clog2(N_REFI);
  localparam int PEND_W = $clog2(PEND_MAX + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [PEND_W-1:0] pend_q;
  logic              tick, inc;

  assign tick   = en_i && (cnt_q == CNT_W'(N_REFI - 1));
  assign full_o = (pend_q == PEND_W'(PEND_MAX));
  assign owed_o = (pend_q != '0);
  assign inc    = tick && !full_o;  // saturate once the deadline is blown

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      if (en_i) cnt_q <= tick ? '0 : cnt_q + 1'b1;
      case ({inc, dec_i})
        2'b10:   pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  a_r6_pend_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= PEND_W'(PEND_MAX));
  a_r6_no_dec_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> owed_o);
endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int CLK_PERIOD_PS   = 10000,
  parameter int T_INIT_NS       = 100000,
  parameter int T_RP_NS         = 20,
  parameter int T_RC_NS         = 70,
  parameter int T_REFI_NS       = 15600,
  parameter int MRD_CYC         = 2,
  parameter int INIT_REFS       = 8,
  parameter int PEND_MAX        = 8,
  parameter int ADDR_W          = 12,
  parameter int BANK_W          = 2,
  parameter int CAS_LAT         = 3,
  parameter int BURST_LEN       = 8,
  parameter int WRAP_INTERLEAVE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sr_req_i,
  input  logic              refresh_grant_i,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic              cke_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] ba_o,
  output logic              init_done_o,
  output logic              refresh_req_o
);
  localparam int N_PWR  = ceil_cyc(T_INIT_NS, CLK_PERIOD_PS);
  localparam int N_RP   = ceil_cyc(T_RP_NS, CLK_PERIOD_PS);
  localparam int N_RC   = ceil_cyc(T_RC_NS, CLK_PERIOD_PS);
  localparam int N_REFI = ceil_cyc(T_REFI_NS, CLK_PERIOD_PS);
  localparam int TMR_W  = $clog2(N_PWR + 2) + 1;
  localparam int IREF_W = $clog2(INIT_REFS + 1);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(mode_word(CAS_LAT, BURST_LEN, WRAP_INTERLEAVE));
  localparam logic [ADDR_W-1:0] PALL_ADDR = ADDR_W'(1 << 10);

  seq_state_e        state_q, state_d;
  logic [3:0]        cmd;
  logic              tmr_load, tmr_done, ref_issue, sr_act;
  logic [TMR_W-1:0]  tmr_val;
  logic [IREF_W-1:0] iref_cnt_q;
  logic              init_done_q, owed, pend_full;

  seq_delay #(.W(TMR_W), .RST_VAL(N_PWR)) u_delay (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .done_o(tmr_done)
  );

  assign sr_act = (state_q == ST_SR_ENTER) || (state_q == ST_SR_HOLD) || (state_q == ST_SR_EXIT);

  refresh_ticker #(.N_REFI(N_REFI), .PEND_MAX(PEND_MAX)) u_ticker (
    .clk_i, .rst_ni, .en_i(init_done_q && !sr_act), .clr_i(sr_act),
    .dec_i(ref_issue), .owed_o(owed), .full_o(pend_full)
  );

  always_comb begin
    state_d   = state_q;
    cmd       = CMD_NOP;
    cke_o     = 1'b1;
    addr_o    = '0;
    tmr_load  = 1'b0;
    tmr_val   = TMR_W'(N_RC - 1);
    ref_issue = 1'b0;
    case (state_q)
      ST_PWRUP:     if (tmr_done) state_d = ST_PRE;
      ST_PRE: begin
        cmd = CMD_PRE; addr_o = PALL_ADDR;
        tmr_load = 1'b1; tmr_val = TMR_W'(N_RP - 1);
        state_d = ST_WAIT_RP;
      end
      ST_WAIT_RP:   if (tmr_done) state_d = ST_IREF;
      ST_IREF: begin
        cmd = CMD_REF; tmr_load = 1'b1; state_d = ST_WAIT_IREF;
      end
      ST_WAIT_IREF: if (tmr_done) state_d = (iref_cnt_q == IREF_W'(INIT_REFS)) ? ST_MRS : ST_IREF;
      ST_MRS: begin
        cmd = CMD_MRS; addr_o = MODE_ADDR;
        tmr_load = 1'b1; tmr_val = TMR_W'(MRD_CYC - 1);
        state_d = ST_WAIT_MRD;
      end
      ST_WAIT_MRD:  if (tmr_done) state_d = ST_IDLE;
      ST_IDLE: begin
        if (pend_full)                    state_d = ST_FREF1;
        else if (refresh_grant_i && owed) state_d = ST_AREF;
        else if (sr_req_i)                state_d = ST_SR_ENTER;
      end
      ST_AREF: begin
        cmd = CMD_REF; tmr_load = 1'b1; ref_issue = 1'b1; state_d = ST_WAIT_AREF;
      end
      ST_WAIT_AREF: if (tmr_done) state_d = ST_IDLE;
      ST_FREF1: begin
        cmd = CMD_REF; tmr_load = 1'b1; ref_issue = 1'b1; state_d = ST_WAIT_F1;
      end
      ST_WAIT_F1:   if (tmr_done) state_d = ST_FREF2;
      ST_FREF2: begin
        cmd = CMD_REF; tmr_load = 1'b1; ref_issue = 1'b1; state_d = ST_WAIT_F2;
      end
      ST_WAIT_F2:   if (tmr_done) state_d = ST_IDLE;
      ST_SR_ENTER: begin
        cmd = CMD_REF; cke_o = 1'b0; state_d = ST_SR_HOLD;
      end
      ST_SR_HOLD: begin
        cke_o = 1'b0;
        if (!sr_req_i) begin
          // exit registers on 2nd edge after CKE high, then a full row cycle
          tmr_load = 1'b1; tmr_val = TMR_W'(N_RC + 1);
          state_d = ST_SR_EXIT;
        end
      end
      ST_SR_EXIT:   if (tmr_done) state_d = ST_IDLE;
      default:      state_d = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_PWRUP;
      iref_cnt_q  <= '0;
      init_done_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IREF) iref_cnt_q <= iref_cnt_q + 1'b1;
      if (state_q == ST_WAIT_MRD && tmr_done) init_done_q <= 1'b1;
    end
  end

  assign {cs_no, ras_no, cas_no, we_no} = cmd;
  assign ba_o          = '0;
  assign init_done_o   = init_done_q;
  assign refresh_req_o = (state_q == ST_IDLE) && owed;

  a_r2_mrs_after_refs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_MRS) |-> (iref_cnt_q == IREF_W'(INIT_REFS)));
  a_r4_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  a_r5_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(refresh_req_o) |-> ($past(refresh_grant_i) || $past(pend_full) || $past(sr_req_i)));
  a_r8_quiet_after_cke: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |=> (cmd == CMD_NOP));
  a_r9_ref_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_REF) |=> (cmd == CMD_NOP));
endmodule

// File: tb/sdram_init_refresh_seq_test.sv
module sdram_init_refresh_seq_test;
  logic clk_i = 1'b0;
  logic rst_ni, sr_req, grant;
  always #5 clk_i = ~clk_i;

  logic cs_n, ras_n, cas_n, we_n, cke, done, req;
  logic [11:0] addr;
  logic [1:0]  ba;
  logic s_cs, s_ras, s_cas, s_we, s_cke, s_done, s_req;
  logic [11:0] s_addr;
  logic [1:0]  s_ba;

  sdram_init_refresh_seq uut (
    .clk_i, .rst_ni, .sr_req_i(sr_req), .refresh_grant_i(grant),
    .cs_no(cs_n), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n), .cke_o(cke),
    .addr_o(addr), .ba_o(ba), .init_done_o(done), .refresh_req_o(req)
  );

  sdram_init_refresh_seq #(.CLK_PERIOD_PS(15000)) uut_slow (
    .clk_i, .rst_ni, .sr_req_i(1'b0), .refresh_grant_i(1'b0),
    .cs_no(s_cs), .ras_no(s_ras), .cas_no(s_cas), .we_no(s_we), .cke_o(s_cke),
    .addr_o(s_addr), .ba_o(s_ba), .init_done_o(s_done), .refresh_req_o(s_req)
  );

  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;
  localparam int N_RC = 7, N_REFI = 1560;

  int checks = 0, fails = 0, ncyc = 0;
  int d_cyc, r_cyc, q_cyc;
  logic [3:0] cmd, s_cmd;
  assign cmd   = {cs_n, ras_n, cas_n, we_n};
  assign s_cmd = {s_cs, s_ras, s_cas, s_we};

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    ncyc++;
  endtask

  task automatic wait_cmd(output int at);
    int n = 0;
    do begin tick(); n++; end while (cmd == NOP && n < 20000);
    at = ncyc;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; sr_req = 1'b0; grant = 1'b0;
    repeat (3) tick();
    chk(cmd == NOP, "R9 reset NOP", cmd, NOP);
    chk(cke && !done && !req, "R1 reset outputs", {cke, done, req}, 3'b100);
    rst_ni = 1'b1;
    ncyc = 0;
  endtask

  task automatic t_powerup();
    int s_ev[3];
    int s_n = 0;
    do begin
      tick();
      if (s_cmd != NOP && s_n < 3) begin s_ev[s_n] = ncyc; s_n++; end
    end while (cmd == NOP && ncyc < 20000);
    chk(ncyc == 10000, "R1 power-up wait", ncyc, 10000);
    chk(cmd == PRE, "R9 precharge code", cmd, PRE);
    chk(addr[10] == 1'b1, "R1 precharge all bit", addr[10], 1);
    chk(s_n == 3 && s_ev[0] == 6667, "R10 slow power-up wait", s_ev[0], 6667);
    chk(s_ev[1] - s_ev[0] == 2, "R10 slow precharge wait", s_ev[1] - s_ev[0], 2);
    chk(s_ev[2] - s_ev[1] == 5, "R10 slow row cycle", s_ev[2] - s_ev[1], 5);
  endtask

  task automatic t_init();
    int prev = ncyc, at;
    for (int i = 0; i < 8; i++) begin
      wait_cmd(at);
      chk(cmd == REF, "R2 init refresh code", cmd, REF);
      chk(at - prev == (i == 0 ? 2 : N_RC), "R2 init gap", at - prev, i == 0 ? 2 : N_RC);
      prev = at;
    end
    wait_cmd(at);
    chk(cmd == MRS, "R2 mode set after 8 refreshes", cmd, MRS);
    chk(at - prev == N_RC, "R2 mode set gap", at - prev, N_RC);
    chk(addr == 12'h033 && ba == 2'b00, "R3 mode word", addr, 12'h033);
    tick();
    chk(!done, "R4 done not early", done, 0);
    tick();
    chk(done, "R4 done after MRD", done, 1);
    d_cyc = ncyc;
  endtask

  task automatic t_refresh_grant();
    do tick(); while (!req && ncyc - d_cyc < 5000);
    r_cyc = ncyc;
    chk(r_cyc - d_cyc == N_REFI, "R5 first request", r_cyc - d_cyc, N_REFI);
    repeat (3) tick();
    chk(req && cmd == NOP, "R5 request held without grant", req, 1);
    grant = 1'b1;
    tick();
    grant = 1'b0;
    chk(cmd == REF, "R5 refresh after grant", cmd, REF);
    chk(!req, "R5 request drops", req, 0);
    tick();
    chk(cmd == NOP && done, "R4 done stays high", done, 1);
  endtask

  task automatic t_forced();
    int r2, f;
    do tick(); while (!req && ncyc - d_cyc < 5000);
    r2 = ncyc;
    chk(r2 - d_cyc == 2 * N_REFI, "R5 periodic request", r2 - d_cyc, 2 * N_REFI);
    wait_cmd(f);
    chk(f - r2 == 7 * N_REFI + 1, "R6 forced refresh time", f - r2, 7 * N_REFI + 1);
    chk(cmd == REF, "R6 forced refresh code", cmd, REF);
    wait_cmd(q_cyc);
    chk(cmd == REF && q_cyc - f == N_RC, "R6 second forced refresh", q_cyc - f, N_RC);
    repeat (6) tick();
    chk(!req, "R6 request low during row cycle", req, 0);
    tick();
    chk(req, "R6 request back after burst", req, 1);
  endtask

  task automatic t_self_refresh();
    int c, at;
    sr_req = 1'b1;
    tick();
    chk(cmd == REF && !cke, "R7 self-refresh entry", {cmd, cke}, {REF, 1'b0});
    repeat (5) begin
      tick();
      chk(!cke && cmd == NOP && !req, "R7 held in self-refresh", {cke, cmd}, {1'b0, NOP});
    end
    sr_req = 1'b0;
    tick();
    c = ncyc;
    chk(cke && cmd == NOP, "R8 CKE returns high", cke, 1);
    sr_req = 1'b1;
    wait_cmd(at);
    chk(at - c == N_RC + 2, "R8 exit quiet time", at - c, N_RC + 2);
    chk(cmd == REF && !cke, "R7 re-entry", {cmd, cke}, {REF, 1'b0});
    sr_req = 1'b0;
    repeat (2) tick();
    chk(cke, "R8 exit again", cke, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_powerup();
    t_init();
    t_refresh_grant();
    t_forced();
    t_self_refresh();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule